// File: doc/BRIEF.md
# AMI Line Encoder with Single Bipolar-Violation Injection

This block turns a serial NRZ transmit bit stream into two unipolar rails, one carrying positive marks and one carrying negative marks, using alternate mark inversion. One bit enters on each rising edge of the line clock. The line clock runs at 2.048 MHz for E1 or 1.544 MHz for T1. Each rail bit is registered, so a bit sampled at edge k drives the rails from edge k until edge k+1.

For line testing, a control input can request one deliberate bipolar violation. Only a low-to-high change of that input arms the request. Once armed, the encoder waits for three ones in a row in the data that follows. It sends the third of those ones with the same polarity as the mark before it. A pending flag shows that a request is waiting. A one-cycle done pulse marks the cycle in which the violating pulse is on the rails.

Top module: `ami_bpv_tx`

## Requirements
- R1: The synchronous reset drives both rails, pending and done low. It also sets the last-mark polarity to negative, so the first one after reset is sent on the positive rail.
- R2: A one sampled at edge k is sent on exactly one rail during the cycle after edge k, with polarity opposite to the previous mark. A zero sampled at edge k leaves both rails low. pos_rail=1 means a positive mark and neg_rail=1 means a negative mark.
- R3: pos_rail and neg_rail are never high in the same cycle.
- R4: A request is armed only at an edge where inject_req is 1 and was 0 at the previous edge. A level held high never re-arms the request. A level that is high when reset is released does not arm it either.
- R5: Once armed, only bits sampled at later edges are counted, and any zero restarts the count. The violation is placed on the third consecutive one.
- R6: The violating pulse has the same polarity as the mark before it. The marks that follow alternate starting from the violating pulse.
- R7: inject_done is high for exactly the one cycle in which the violating pulse is on the rails. inject_pending is high from the cycle after the arming edge, and it falls in the same cycle that inject_done rises.
- R8: A new 0-to-1 edge of inject_req while a request is pending is absorbed. This includes an edge at the violating edge. Each pending period therefore produces exactly one violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | NRZ transmit bit |
| inject_req | input | 1 | Violation request; its rising edge arms one insertion |
| pos_rail | output | 1 | Positive-mark rail |
| neg_rail | output | 1 | Negative-mark rail |
| inject_pending | output | 1 | High while an armed request waits for its run of ones |
| inject_done | output | 1 | One-cycle pulse in the cycle the violation is sent |

## Verification
A wrong last-mark polarity is visible on the rails at the next one: that mark lands on the wrong rail one cycle after its bit is sampled. A fault in the run counter or the armed flag shows up as inject_done and the doubled polarity appearing too early, too late, or never. This is seen at the latest on the third one after arming, and the pending flag exposes a stuck armed state in every cycle. Random data with random request toggles is compared, cycle by cycle, against a bench model of both rails and both flags. Directed sequences cover held-high requests, runs broken by zeros, and edges that arrive while a request is pending.

// File: rtl/ami_bpv_pkg.sv
package ami_bpv_pkg;

  typedef enum logic {
    MARK_NEG = 1'b0,
    MARK_POS = 1'b1
  } mark_pol_t;

  // Polarity of the next mark: alternate unless a violation is forced.
  function automatic mark_pol_t pick_pol(mark_pol_t last, logic violate);
    if (violate) return last;
    return (last == MARK_POS) ? MARK_NEG : MARK_POS;
  endfunction

  // Rail pair {pos, neg} for one bit at a given polarity.
  function automatic logic [1:0] rails_of(logic bit_one, mark_pol_t p);
    if (!bit_one) return 2'b00;
    return (p == MARK_POS) ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/ami_arm_edge.sv
module ami_arm_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic rise_o
);
  logic req_q;

  // Reset value 1: a level already high at reset release does not arm.
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b1;
    else     req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;

  // R4: an edge can never be reported on two consecutive edges
  a_r4_no_double_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ami_run_watch.sv
module ami_run_watch #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic bit_i,
  output logic fire_o,
  output logic pending_o
);
  localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RUN_LEN - 1);

  logic             armed;
  logic [CNT_W-1:0] run_cnt;

  assign fire_o    = armed & bit_i & (run_cnt == LAST_IDX);
  assign pending_o = armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      run_cnt <= '0;
    end else begin
      if (fire_o)      armed <= 1'b0;
      else if (rise_i) armed <= 1'b1;

      if (!armed || fire_o || !bit_i) run_cnt <= '0;
      else                            run_cnt <= run_cnt + 1'b1;
    end
  end

  // R5: the run count stays below the run length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST_IDX);

  // R5: a zero seen while armed restarts the run
  a_r5_zero_restarts: assert property (@(posedge clk) disable iff (rst)
    (armed && !bit_i) |=> (run_cnt == '0));

  // R8: a firing always ends the pending period, even with a new edge
  a_r8_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !armed);

endmodule

// File: rtl/ami_polarity_enc.sv
module ami_polarity_enc
  import ami_bpv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic viol_i,
  output logic pos_o,
  output logic neg_o,
  output logic done_o
);
  mark_pol_t  last_pol;
  mark_pol_t  this_pol;
  logic [1:0] rails_nx;

  assign this_pol = pick_pol(last_pol, viol_i);
  assign rails_nx = rails_of(bit_i, this_pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pol <= MARK_NEG;
      pos_o    <= 1'b0;
      neg_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      if (bit_i) last_pol <= this_pol;
      pos_o  <= rails_nx[1];
      neg_o  <= rails_nx[0];
      done_o <= viol_i & bit_i;
    end
  end

  // R3: rails are mutually exclusive
  a_r3_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pos_o && neg_o));

  // R2: a zero leaves both rails low in the next cycle
  a_r2_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    !bit_i |=> (!pos_o && !neg_o));

  // R2: a normal mark takes the opposite polarity of the previous mark
  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    (bit_i && !viol_i) |=> (pos_o == ($past(last_pol) == MARK_NEG)));

  // R6: a violating mark repeats the previous polarity
  a_r6_repeat_pol: assert property (@(posedge clk) disable iff (rst)
    (bit_i && viol_i) |=> (pos_o == ($past(last_pol) == MARK_POS)));

endmodule

// File: rtl/ami_bpv_tx.sv
module ami_bpv_tx #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic inject_req,
  output logic pos_rail,
  output logic neg_rail,
  output logic inject_pending,
  output logic inject_done
);
  logic rise_evt;
  logic fire_evt;

  ami_arm_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_i  (inject_req),
    .rise_o (rise_evt)
  );

  ami_run_watch #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise_evt),
    .bit_i     (data_in),
    .fire_o    (fire_evt),
    .pending_o (inject_pending)
  );

  ami_polarity_enc u_enc (
    .clk    (clk),
    .rst    (rst),
    .bit_i  (data_in),
    .viol_i (fire_evt),
    .pos_o  (pos_rail),
    .neg_o  (neg_rail),
    .done_o (inject_done)
  );

  // R7: pending only rises after a detected request edge
  a_r7_pending_from_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(inject_pending) |-> $past(rise_evt));

  // R7: done and pending are never high together
  a_r7_done_ends_pending: assert property (@(posedge clk) disable iff (rst)
    inject_done |-> !inject_pending);

  // R7: done carries a mark on the rails
  a_r7_done_with_mark: assert property (@(posedge clk) disable iff (rst)
    inject_done |-> (pos_rail || neg_rail));

endmodule

// File: tb/sim_ami_bpv_tx.sv
module sim_ami_bpv_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic inject_req = 1'b0;
  logic pos_rail, neg_rail, inject_pending, inject_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int done_seen = 0;

  // bench model state
  logic m_req_q, m_armed, m_last_pos;
  int   m_run;
  logic e_pos, e_neg, e_pend, e_done;

  always #2 clk = ~clk;

  ami_bpv_tx u0 (
    .clk(clk), .rst(rst), .data_in(data_in), .inject_req(inject_req),
    .pos_rail(pos_rail), .neg_rail(neg_rail),
    .inject_pending(inject_pending), .inject_done(inject_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // bench model: which polarity a mark takes
  function automatic logic mark_pos(logic last_pos, logic viol);
    return viol ? last_pos : ~last_pos;
  endfunction

  task automatic compare_all(input string tag);
    check(pos_rail == e_pos, tag, "pos_rail", pos_rail, e_pos);
    check(neg_rail == e_neg, tag, "neg_rail", neg_rail, e_neg);
    check(inject_pending == e_pend, "R7", "pending", inject_pending, e_pend);
    check(inject_done == e_done, e_done ? "R5" : "R7", "done", inject_done, e_done);
    check(!(pos_rail && neg_rail), "R3", "rails both high", 1, 0);
    if (inject_done) done_seen++;
  endtask

  task automatic do_reset(input logic rq);
    @(negedge clk);
    rst = 1'b1; inject_req = rq; data_in = 1'b0;
    @(posedge clk); #1;
    m_req_q = 1'b1; m_armed = 1'b0; m_run = 0; m_last_pos = 1'b0;
    e_pos = 0; e_neg = 0; e_pend = 0; e_done = 0;
    compare_all("R1");
  endtask

  task automatic step(input logic d, input logic rq, input string tag);
    logic rise, viol, p;
    @(negedge clk);
    rst = 1'b0; data_in = d; inject_req = rq;
    rise = rq & ~m_req_q;
    viol = m_armed & d & (m_run == 2);
    p = mark_pos(m_last_pos, viol);
    e_pos = d & p;
    e_neg = d & ~p;
    e_done = viol;
    if (d) m_last_pos = p;
    if (!m_armed || viol || !d) m_run = 0; else m_run++;
    if (viol) m_armed = 1'b0; else if (rise) m_armed = 1'b1;
    e_pend = m_armed;
    m_req_q = rq;
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R1, R4: request high through reset must not arm; first mark positive
    do_reset(1'b1);
    step(1'b1, 1'b1, "R1");
    check(pos_rail == 1'b1, "R1", "first mark positive", pos_rail, 1);
    done_seen = 0;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R4");
    check(done_seen == 0, "R4", "held level armed", done_seen, 0);
    check(inject_pending == 1'b0, "R4", "pending after held level", inject_pending, 0);

    // R5: arm, then a run broken by a zero; violation on 3rd consecutive one
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R7");
    check(inject_pending == 1'b1, "R7", "pending after edge", inject_pending, 1);
    done_seen = 0;
    step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    check(done_seen == 0, "R5", "early violation", done_seen, 0);
    step(1'b1, 1'b1, "R6");
    check(inject_done == 1'b1, "R5", "violation on third one", inject_done, 1);
    // R6: the violating mark repeats the previous polarity (previous was positive)
    check(pos_rail == 1'b1, "R6", "violation polarity", pos_rail, 1);
    step(1'b1, 1'b1, "R6");
    check(neg_rail == 1'b1, "R6", "alternation after violation", neg_rail, 1);

    // R8: edge during pending is absorbed, exactly one violation
    step(1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    done_seen = 0;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, "R8");
    check(done_seen == 1, "R8", "violations per pending period", done_seen, 1);

    // random traffic with occasional request toggles and resets
    for (int i = 0; i < 4000; i++) begin
      logic d, rq;
      d  = ($urandom % 4) != 0;
      rq = ($urandom % 6) == 0 ? ~inject_req : inject_req;
      if (($urandom % 500) == 0) do_reset(rq);
      else step(d, rq, "R2");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule